// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block is the interrupt front end of a memory-mapped host controller. It keeps two 32-bit registers: a latched event register and an enable mask. Software never writes either register directly. Each register has two addresses, one where each 1 in the write data sets the matching bit and one where each 1 clears it. Bits written as 0 are left alone, so concurrent agents never need a read-modify-write.

Hardware sources pulse `hw_event` to latch event bits. Each bit stays set until software clears it. Bit 31 of the mask is a master gate and enables no source of its own. The single interrupt line is a registered AND of that gate with the OR of event-and-enable over bits 30..0. Positions 28 and 14..10 are reserved and always read as zero.

Address decoding names five selections: `SEL_EVT_SET` (0x80), `SEL_EVT_CLR` (0x84), `SEL_MSK_SET` (0x88), `SEL_MSK_CLR` (0x8C) and `SEL_NONE` (any other offset). The registers take no transitions other than bit set, bit clear and hold.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A write to offset 0x88 sets each mask bit whose write-data bit is 1. Every other mask bit is unchanged.
- R2: A write to offset 0x8C clears each mask bit whose write-data bit is 1. Every other mask bit is unchanged.
- R3: `bus_rdata` returns the mask register when `bus_addr` is 0x88 or 0x8C, and the event register when `bus_addr` is 0x80 or 0x84.
- R4: While mask bit 31 is 0, `irq_o` stays 0 whatever the other mask and event bits hold.
- R5: For bits 30..0, an event bit raises the interrupt only if the mask bit at the same position is also 1. Event bit 31 never contributes.
- R6: Bits 28 and 14..10 of both registers read as 0, and writes and hardware pulses at those positions have no effect.
- R7: A write to offset 0x80 sets event bits and a write to offset 0x84 clears event bits, with the same one-hot write-data meaning as the mask.
- R8: After reset both registers are 0 and `irq_o` is 0.
- R9: A 1 on `hw_event[i]` at a non-reserved position sets event bit i, and the bit stays set until software clears it. If a hardware set and a software clear hit the same bit in the same cycle, the bit ends set.
- R10: `irq_o` is registered. It reflects the register contents one clock after they change.
- R11: Any offset other than the four above reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_wdata | input | 32 | Write data, one bit per register bit |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| hw_event | input | 32 | Hardware event pulses, one per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A hardware event pulse and a software clear of the event register can hit the same bit in the same clock. The bench provokes this on purpose by driving `hw_event` together with a write to offset 0x84 whose data covers the pulsed bit and some neighbours. The pulsed bit must read back set and the neighbours cleared. A behavioural model, updated on every edge with set-over-clear priority, judges every read and the interrupt line on every clock. The bench also runs long stretches where pseudo-random pulses and writes overlap.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_EVT_SET = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_EVT_CLR = 8'h84;
    localparam logic [ADDR_W-1:0] OFF_MSK_SET = 8'h88;
    localparam logic [ADDR_W-1:0] OFF_MSK_CLR = 8'h8C;

    // reserved positions: bit 28 and bits 14..10
    localparam logic [DATA_W-1:0] RSVD_BITS = 32'h1000_7C00;
    localparam int GATE_BIT = DATA_W - 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EVT_SET,
        SEL_EVT_CLR,
        SEL_MSK_SET,
        SEL_MSK_CLR
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFF_EVT_SET: s = SEL_EVT_SET;
            OFF_EVT_CLR: s = SEL_EVT_CLR;
            OFF_MSK_SET: s = SEL_MSK_SET;
            OFF_MSK_CLR: s = SEL_MSK_CLR;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irq_sc_reg.sv
module irq_sc_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] RSVD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] set_all;
    logic [W-1:0] q_nxt;

    always_comb begin
        set_all = (sw_set | hw_set) & ~RSVD;
        // set has priority over clear on the same bit
        q_nxt   = ((q & ~sw_clr) | set_all) & ~RSVD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // R9, R1, R7: every requested set bit (non-reserved) is present next cycle
    assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past((sw_set | hw_set) & ~RSVD)) == $past((sw_set | hw_set) & ~RSVD)));

    // R2, R7: a clear with no concurrent set empties the bit
    assert_clr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(sw_clr & ~(sw_set | hw_set))) == '0));

    // R6: reserved positions never hold a 1
    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q & RSVD) == '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] msk,
    output logic         irq_o
);
    localparam logic [W-1:0] SRC_BITS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] hits;
    logic         irq_nxt;

    always_comb begin
        hits    = evt & msk & SRC_BITS;
        irq_nxt = msk[W-1] & (|hits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_nxt;
    end

    // R4: gate low means no interrupt on the following cycle
    assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !msk[W-1] |=> !irq_o);

    // R5: no enabled source pending means no interrupt on the following cycle
    assert_no_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt[W-2:0] & msk[W-2:0]) == '0) |=> !irq_o);

    // R10: a gated, pending source raises the line one cycle later
    assert_irq_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msk[W-1] && ((evt[W-2:0] & msk[W-2:0]) != '0)) |=> irq_o);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] hw_event,
    output logic              irq_o
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] evt_set, evt_clr, msk_set, msk_clr;
    logic [DATA_W-1:0] evt_q, msk_q;

    always_comb begin
        sel     = decode_sel(bus_addr);
        evt_set = '0;
        evt_clr = '0;
        msk_set = '0;
        msk_clr = '0;
        if (bus_wr) begin
            unique case (sel)
                SEL_EVT_SET: evt_set = bus_wdata;
                SEL_EVT_CLR: evt_clr = bus_wdata;
                SEL_MSK_SET: msk_set = bus_wdata;
                SEL_MSK_CLR: msk_clr = bus_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_EVT_SET, SEL_EVT_CLR: bus_rdata = evt_q;
            SEL_MSK_SET, SEL_MSK_CLR: bus_rdata = msk_q;
            default:                  bus_rdata = '0;
        endcase
    end

    irq_sc_reg #(.W(DATA_W), .RSVD(RSVD_BITS)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (evt_set),
        .sw_clr (evt_clr),
        .hw_set (hw_event),
        .q      (evt_q)
    );

    irq_sc_reg #(.W(DATA_W), .RSVD(RSVD_BITS)) u_msk (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (msk_set),
        .sw_clr (msk_clr),
        .hw_set ('0),
        .q      (msk_q)
    );

    irq_gate #(.W(DATA_W)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_q),
        .msk   (msk_q),
        .irq_o (irq_o)
    );

    // R11: unmapped offsets read as zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0));

    // R11: a write to an unmapped offset leaves the mask unchanged
    assert_unmapped_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_NONE) |=> $stable(msk_q));

    // R6: reserved positions are never seen on the read bus
    assert_rdata_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSVD_BITS) == '0);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
    localparam logic [31:0] RSV = 32'h1000_7C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_event = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    string phase = "R8";

    logic [31:0] m_evt = '0, m_msk = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_event(hw_event), .irq_o(irq_o)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_evt = '0; m_msk = '0; m_irq = 1'b0;
        end else begin
            logic any;
            logic [31:0] e_nxt, m_nxt;
            any = 1'b0;
            for (int i = 0; i < 31; i++) if (m_evt[i] && m_msk[i]) any = 1'b1;
            m_irq = m_msk[31] && any;
            e_nxt = m_evt; m_nxt = m_msk;
            for (int i = 0; i < 32; i++) begin
                if (bus_wr && bus_addr == 8'h84 && bus_wdata[i]) e_nxt[i] = 1'b0;
                if (bus_wr && bus_addr == 8'h8C && bus_wdata[i]) m_nxt[i] = 1'b0;
                if (bus_wr && bus_addr == 8'h80 && bus_wdata[i]) e_nxt[i] = 1'b1;
                if (bus_wr && bus_addr == 8'h88 && bus_wdata[i]) m_nxt[i] = 1'b1;
                if (hw_event[i]) e_nxt[i] = 1'b1;
                if (RSV[i]) begin e_nxt[i] = 1'b0; m_nxt[i] = 1'b0; end
            end
            m_evt = e_nxt; m_msk = m_nxt;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h80 || a == 8'h84) return m_evt;
        if (a == 8'h88 || a == 8'h8C) return m_msk;
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        chk({phase, " rdata"}, bus_rdata, model_read(bus_addr));
        chk({phase, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    end

    task automatic drive(input logic [7:0] a, input logic w, input logic [31:0] d,
                         input logic [31:0] h);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = w; bus_wdata = d; hw_event = h;
    endtask

    task automatic idle();
        drive(8'h00, 1'b0, '0, '0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        drive(a, 1'b0, '0, '0);
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        idle(); idle();
        @(negedge clk);
        chk(tag, {31'b0, irq_o}, {31'b0, exp});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset irq", {31'b0, irq_o}, 32'h0);
        rd_chk("R8 reset event", 8'h80, 32'h0);
        rd_chk("R8 reset mask", 8'h88, 32'h0);

        phase = "R1";
        drive(8'h88, 1'b1, 32'hFFFF_FFFF, '0);
        rd_chk("R1 mask set all", 8'h88, 32'hEFFF_83FF);
        rd_chk("R3 mask via clear addr", 8'h8C, 32'hEFFF_83FF);

        phase = "R2";
        drive(8'h8C, 1'b1, 32'h8000_00F0, '0);
        rd_chk("R2 mask partial clear", 8'h88, 32'h6FFF_830F);

        phase = "R7";
        drive(8'h80, 1'b1, 32'h0000_0001, '0);
        rd_chk("R7 event set", 8'h84, 32'h0000_0001);
        phase = "R4";
        irq_chk("R4 gate off blocks", 1'b0);
        drive(8'h88, 1'b1, 32'h8000_0000, '0);
        idle();
        @(negedge clk);
        chk("R10 irq not yet", {31'b0, irq_o}, 32'h0);
        idle();
        @(negedge clk);
        chk("R10 irq after one clock", {31'b0, irq_o}, 32'h1);

        phase = "R5";
        drive(8'h84, 1'b1, 32'h0000_0001, '0);
        drive(8'h80, 1'b1, 32'h0000_0010, '0);
        irq_chk("R5 masked-off source", 1'b0);
        drive(8'h80, 1'b1, 32'h8000_0000, '0);
        irq_chk("R5 event bit 31 no effect", 1'b0);
        drive(8'h84, 1'b1, 32'hFFFF_FFFF, '0);

        phase = "R6";
        drive(8'h80, 1'b1, 32'h1000_7C00, 32'h1000_7C00);
        rd_chk("R6 reserved event", 8'h80, 32'h0);
        drive(8'h8C, 1'b1, 32'hFFFF_FFFF, '0);
        drive(8'h88, 1'b1, 32'h1000_7C00, '0);
        rd_chk("R6 reserved mask", 8'h88, 32'h0);

        phase = "R9";
        drive(8'h00, 1'b0, '0, 32'h0000_0200);
        idle(); idle();
        rd_chk("R9 hw event sticky", 8'h80, 32'h0000_0200);
        drive(8'h84, 1'b1, 32'h0000_0300, 32'h0000_0200);
        rd_chk("R9 set beats clear", 8'h80, 32'h0000_0200);
        drive(8'h80, 1'b1, 32'h0000_0100, '0);
        drive(8'h84, 1'b1, 32'h0000_0300, 32'h0000_0100);
        rd_chk("R9 set beats clear neighbour", 8'h80, 32'h0000_0100);

        phase = "R11";
        drive(8'h88, 1'b1, 32'h0000_0001, '0);
        drive(8'h90, 1'b1, 32'hFFFF_FFFF, '0);
        rd_chk("R11 unmapped read", 8'h90, 32'h0);
        rd_chk("R11 unmapped write ignored", 8'h88, 32'h0000_0001);
        drive(8'h86, 1'b1, 32'hFFFF_FFFF, '0);
        rd_chk("R11 event unchanged", 8'h80, 32'h0000_0100);

        phase = "R10";
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            case (lfsr[2:0])
                3'd0: a = 8'h80; 3'd1: a = 8'h84; 3'd2: a = 8'h88;
                3'd3: a = 8'h8C; 3'd4: a = 8'h9C; default: a = 8'h88;
            endcase
            drive(a, lfsr[3], {lfsr[31:4], lfsr[7:4]}, lfsr[9] ? (32'h1 << lfsr[14:10]) : 32'h0);
        end
        idle(); idle();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule